// File: doc/BRIEF.md
# Oversampling Serial Byte Receiver

This block takes a single asynchronous receive line and a sample-tick enable, which strobes at sixteen times the bit rate, and recovers framed characters from them. The line first passes through a two-flop synchronizer. A falling edge arms the receiver. The start bit is confirmed at its middle, and every later bit is decided by a three-sample majority vote taken around its centre. The receiver takes its framing options at run time: a character length of 5 to 8 bits, parity off, even or odd, and one or two stop bits. These options must stay constant while a character is being received.

Each completed character goes into a one-character holding register, which has a valid output and a read-acknowledge strobe. Alongside the data, the block keeps sticky indications for framing, parity, noise and overrun errors. It also reports a break, meaning the line has stayed low for longer than a full frame, and an idle line, meaning the line has stayed quiet for a full frame after a burst ended.

Top module: `serial_rx_sampler`

## Requirements
- R1: After reset, `rd_valid` and every error and status output read 0.
- R2: A low level seen on a tick while the line is armed counts as tick 0 of a start bit. If the line is high again at tick 8, the event is dropped, no character is produced, and the receiver waits for the next edge.
- R3: Data bits are taken LSB first, one bit every 16 ticks. `cfg_len` selects the character length (0=5, 1=6, 2=7, 3=8 bits). The character appears right-aligned on `rd_data` with the unused upper bits at 0, and `rd_valid` rises once the last stop bit has been decided.
- R4: With `cfg_par_en`=1, a parity bit follows the data. `cfg_par_odd`=0 selects even parity and 1 selects odd. `err_parity` is set if the received parity bit does not fit the data, and the character is still delivered.
- R5: `err_frame` is set if any stop bit is decided low. With `cfg_two_stop`=1, both stop bits are checked.
- R6: Each data, parity and stop bit is decided by majority over the samples at ticks 7, 8 and 9 of the bit. If those three samples disagree, `err_noise` is set and the majority value is kept.
- R7: If a character completes while `rd_valid` is still high and no `rd_ack` arrives in the same cycle, `err_overrun` is set, the new character is dropped, and `rd_data` keeps the old character.
- R8: `brk_det` is set once the line has been low for more than one frame time (16 × (start + data + parity + stop) ticks). It is not set at 150 low ticks in 8N1, which has a 160-tick frame.
- R9: `idle_det` is set after the line has stayed high for one frame time since the last character completed. It fires only once per burst and is not raised again until another character has been received.
- R10: `rd_ack` clears `rd_valid` and the frame, parity, noise and overrun flags. `flag_clear` clears all six flags, and leaves `rd_valid` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Sample enable, 16 per bit period |
| rx_in | input | 1 | Asynchronous receive line, idle high |
| cfg_len | input | 2 | Character length code (0..3 = 5..8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_two_stop | input | 1 | Two stop bits |
| rd_ack | input | 1 | Read strobe for the holding register |
| flag_clear | input | 1 | Clears all sticky flags |
| rd_data | output | 8 | Received character, right-aligned |
| rd_valid | output | 1 | Holding register holds an unread character |
| err_frame | output | 1 | A stop bit was low |
| err_parity | output | 1 | Parity mismatch |
| err_noise | output | 1 | Disagreeing samples within a bit |
| err_overrun | output | 1 | A character was lost |
| brk_det | output | 1 | Line low for longer than a frame |
| idle_det | output | 1 | Line idle for a frame after a burst |

## Verification
A change on `rx_in` takes two clocks through the synchronizer, so it is first seen by the next tick. Each character is decided at tick 9 of its last stop bit, and `rd_valid` and the error flags follow one clock after that tick. `brk_det` and `idle_det` are registered on the tick that completes their count. The bench moves the line only on the falling clock edge just before a tick is taken, so each bench bit covers exactly 16 ticks (phases 0 to 15). A one-tick disturbance can therefore be aimed at phase 8 of a bit. Results are read only after the stimulus has ended, once the frame's stop period or a stated tick count has fully passed, which is always later than the cycle in which the output is due.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} rx_state_t;

  function automatic logic [3:0] data_len(input logic [1:0] code);
    return 4'd5 + {2'b00, code};
  endfunction
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], d_async};
  end

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/srx_bit_engine.sv
module srx_bit_engine import srx_pkg::*; #(
  parameter int OSR      = 16,
  parameter int MAX_BITS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                rx_s,
  input  logic [1:0]          cfg_len,
  input  logic                cfg_par_en,
  input  logic                cfg_par_odd,
  input  logic                cfg_two_stop,
  output logic                done,
  output logic [MAX_BITS-1:0] done_data,
  output logic                done_ferr,
  output logic                done_perr,
  output logic                done_noise
);
  localparam int PW = $clog2(OSR);
  localparam logic [PW-1:0] PH_LO  = PW'(OSR/2 - 1);
  localparam logic [PW-1:0] PH_MID = PW'(OSR/2);
  localparam logic [PW-1:0] PH_HI  = PW'(OSR/2 + 1);
  localparam logic [PW-1:0] PH_END = PW'(OSR - 1);

  rx_state_t st_q, st_n;
  logic [PW-1:0] ph_q, ph_n;
  logic [3:0] bit_q, bit_n;
  logic [MAX_BITS-1:0] sh_q, sh_n;
  logic par_q, par_n, perr_q, perr_n, ferr_q, ferr_n, noise_q, noise_n;
  logic sa_q, sa_n, sb_q, sb_n, armed_q, armed_n, done_q, done_n;
  logic [3:0] nbits, nstop;
  logic vote, split;

  assign nbits = data_len(cfg_len);
  assign nstop = cfg_two_stop ? 4'd2 : 4'd1;
  assign vote  = (sa_q & sb_q) | (sa_q & rx_s) | (sb_q & rx_s);
  assign split = !((sa_q == sb_q) && (sb_q == rx_s));

  always_comb begin
    st_n = st_q; ph_n = ph_q; bit_n = bit_q; sh_n = sh_q;
    par_n = par_q; perr_n = perr_q; ferr_n = ferr_q; noise_n = noise_q;
    sa_n = sa_q; sb_n = sb_q; armed_n = armed_q; done_n = 1'b0;
    if (tick) begin
      ph_n = (ph_q == PH_END) ? '0 : ph_q + 1'b1;
      if (ph_q == PH_LO)  sa_n = rx_s;
      if (ph_q == PH_MID) sb_n = rx_s;
      case (st_q)
        S_IDLE: begin
          ph_n = '0;
          if (rx_s) armed_n = 1'b1;
          else if (armed_q) begin
            st_n = S_START; armed_n = 1'b0; ph_n = PW'(1);
          end
        end
        S_START: begin
          if (ph_q == PH_MID && rx_s) begin
            st_n = S_IDLE; ph_n = '0; armed_n = 1'b1;
          end else if (ph_q == PH_END) begin
            st_n = S_DATA; bit_n = '0; sh_n = '0; par_n = 1'b0;
            perr_n = 1'b0; ferr_n = 1'b0; noise_n = 1'b0;
          end
        end
        S_DATA: begin
          if (ph_q == PH_HI) begin
            sh_n = {vote, sh_q[MAX_BITS-1:1]};
            par_n = par_q ^ vote;
            noise_n = noise_q | split;
          end
          if (ph_q == PH_END) begin
            if (bit_q == nbits - 4'd1) begin
              bit_n = '0; st_n = cfg_par_en ? S_PAR : S_STOP;
            end else bit_n = bit_q + 4'd1;
          end
        end
        S_PAR: begin
          if (ph_q == PH_HI) begin
            perr_n = vote ^ par_q ^ cfg_par_odd;
            noise_n = noise_q | split;
          end
          if (ph_q == PH_END) begin
            st_n = S_STOP; bit_n = '0;
          end
        end
        S_STOP: begin
          if (ph_q == PH_HI) begin
            ferr_n = ferr_q | !vote;
            noise_n = noise_q | split;
            if (bit_q == nstop - 4'd1) begin
              done_n = 1'b1; st_n = S_IDLE; ph_n = '0;
            end
          end
          if (ph_q == PH_END) bit_n = bit_q + 4'd1;
        end
        default: st_n = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; ph_q <= '0; bit_q <= '0; sh_q <= '0;
      par_q <= 1'b0; perr_q <= 1'b0; ferr_q <= 1'b0; noise_q <= 1'b0;
      sa_q <= 1'b1; sb_q <= 1'b1; armed_q <= 1'b0; done_q <= 1'b0;
    end else begin
      st_q <= st_n; ph_q <= ph_n; bit_q <= bit_n; sh_q <= sh_n;
      par_q <= par_n; perr_q <= perr_n; ferr_q <= ferr_n; noise_q <= noise_n;
      sa_q <= sa_n; sb_q <= sb_n; armed_q <= armed_n; done_q <= done_n;
    end
  end

  assign done       = done_q;
  assign done_data  = sh_q >> (4'(MAX_BITS) - nbits);
  assign done_ferr  = ferr_q;
  assign done_perr  = perr_q;
  assign done_noise = noise_q;

  // R2: a start bit that is high again at mid-bit returns the engine to idle
  assert_glitch_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && st_q == S_START && ph_q == PH_MID && rx_s) |=> (st_q == S_IDLE));
  // R3: a character completes only on a sample tick
  assert_done_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(tick));
endmodule

// File: rtl/srx_line_watch.sv
module srx_line_watch #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rx_s,
  input  logic          done,
  input  logic [CW-1:0] frame_ticks,
  input  logic          flag_clear,
  output logic          brk_det,
  output logic          idle_det
);
  logic [CW-1:0] low_q, low_n, hi_q, hi_n;
  logic brk_q, brk_n, arm_q, arm_n, idle_q, idle_n;

  always_comb begin
    low_n = low_q; hi_n = hi_q; arm_n = arm_q;
    brk_n  = brk_q  & !flag_clear;
    idle_n = idle_q & !flag_clear;
    if (tick) begin
      if (!rx_s) begin
        hi_n = '0;
        if (low_q == frame_ticks) brk_n = 1'b1;
        else low_n = low_q + 1'b1;
      end else begin
        low_n = '0;
        if (arm_q) begin
          if (hi_q == frame_ticks - 1'b1) begin
            idle_n = 1'b1; arm_n = 1'b0;
          end else hi_n = hi_q + 1'b1;
        end
      end
    end
    if (done) begin
      arm_n = 1'b1; hi_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q <= '0; hi_q <= '0; brk_q <= 1'b0; arm_q <= 1'b0; idle_q <= 1'b0;
    end else begin
      low_q <= low_n; hi_q <= hi_n; brk_q <= brk_n; arm_q <= arm_n; idle_q <= idle_n;
    end
  end

  assign brk_det  = brk_q;
  assign idle_det = idle_q;

  // R8: break can only be raised after a low sample
  assert_break_on_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_q) |-> !$past(rx_s));
  // R9: idle can only be raised after a high sample and consumes the arm
  assert_idle_on_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_q) |-> ($past(rx_s) && !arm_q));
endmodule

// File: rtl/serial_rx_sampler.sv
module serial_rx_sampler import srx_pkg::*; #(
  parameter int OSR      = 16,
  parameter int MAX_BITS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                os_tick,
  input  logic                rx_in,
  input  logic [1:0]          cfg_len,
  input  logic                cfg_par_en,
  input  logic                cfg_par_odd,
  input  logic                cfg_two_stop,
  input  logic                rd_ack,
  input  logic                flag_clear,
  output logic [MAX_BITS-1:0] rd_data,
  output logic                rd_valid,
  output logic                err_frame,
  output logic                err_parity,
  output logic                err_noise,
  output logic                err_overrun,
  output logic                brk_det,
  output logic                idle_det
);
  localparam int CW = $clog2(OSR * (MAX_BITS + 4) + 1);

  logic rx_s, eng_done, eng_ferr, eng_perr, eng_noise;
  logic [MAX_BITS-1:0] eng_data;
  logic [CW-1:0] frame_ticks;

  assign frame_ticks = CW'(OSR) * (CW'(2) + CW'(data_len(cfg_len))
                       + CW'(cfg_par_en) + CW'(cfg_two_stop));

  srx_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(rx_in), .q_sync(rx_s));

  srx_bit_engine #(.OSR(OSR), .MAX_BITS(MAX_BITS)) u_engine (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .rx_s(rx_s),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .done(eng_done), .done_data(eng_data),
    .done_ferr(eng_ferr), .done_perr(eng_perr), .done_noise(eng_noise));

  srx_line_watch #(.CW(CW)) u_watch (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .rx_s(rx_s), .done(eng_done),
    .frame_ticks(frame_ticks), .flag_clear(flag_clear),
    .brk_det(brk_det), .idle_det(idle_det));

  logic [MAX_BITS-1:0] data_q, data_n;
  logic val_q, val_n, fe_q, fe_n, pe_q, pe_n, ne_q, ne_n, ov_q, ov_n;
  logic wipe, lose;

  assign wipe = rd_ack | flag_clear;
  assign lose = eng_done & val_q & !rd_ack;

  always_comb begin
    data_n = data_q;
    val_n  = val_q & !rd_ack;
    fe_n = fe_q & !wipe;
    pe_n = pe_q & !wipe;
    ne_n = ne_q & !wipe;
    ov_n = ov_q & !wipe;
    if (lose) ov_n = 1'b1;
    else if (eng_done) begin
      data_n = eng_data;
      val_n  = 1'b1;
      fe_n = fe_n | eng_ferr;
      pe_n = pe_n | eng_perr;
      ne_n = ne_n | eng_noise;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0; val_q <= 1'b0; fe_q <= 1'b0; pe_q <= 1'b0; ne_q <= 1'b0; ov_q <= 1'b0;
    end else begin
      data_q <= data_n; val_q <= val_n; fe_q <= fe_n; pe_q <= pe_n; ne_q <= ne_n; ov_q <= ov_n;
    end
  end

  assign rd_data     = data_q;
  assign rd_valid    = val_q;
  assign err_frame   = fe_q;
  assign err_parity  = pe_q;
  assign err_noise   = ne_q;
  assign err_overrun = ov_q;

  // R7: a character arriving on an unread register is dropped and flagged
  assert_overrun_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && val_q && !rd_ack) |=> (ov_q && $stable(data_q)));
  // R10: a read strobe without a new character empties the register
  assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && !eng_done) |=> !val_q);
  // R3: an accepted character always makes the register valid
  assert_load_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && !(val_q && !rd_ack)) |=> val_q);
endmodule

// File: tb/serial_rx_sampler_test.sv
`timescale 1ns/1ps
module serial_rx_sampler_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1;
  logic [1:0] cfg_len = 2'd3;
  logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
  logic rd_ack = 1'b0, flag_clear = 1'b0;
  logic [7:0] rd_data;
  logic rd_valid, err_frame, err_parity, err_noise, err_overrun, brk_det, idle_det;
  logic [1:0] div_q = 2'd0;
  logic os_tick;
  int vectors = 0, fails = 0;

  always #2 clk = ~clk;

  always @(posedge clk) div_q <= div_q + 2'd1;
  assign os_tick = (div_q == 2'd3);

  serial_rx_sampler uut (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_in(rx),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .rd_ack(rd_ack), .flag_clear(flag_clear),
    .rd_data(rd_data), .rd_valid(rd_valid), .err_frame(err_frame),
    .err_parity(err_parity), .err_noise(err_noise), .err_overrun(err_overrun),
    .brk_det(brk_det), .idle_det(idle_det));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  // leaves the bench at the falling edge just before a tick is taken
  task automatic wait_tick;
    @(negedge clk);
    while (!os_tick) @(negedge clk);
  endtask

  task automatic put(input logic lvl, input int n);
    rx = lvl;
    for (int i = 0; i < n; i++) wait_tick();
  endtask

  task automatic pulse_clear;
    flag_clear = 1'b1; rd_ack = 1'b1;
    @(negedge clk);
    flag_clear = 1'b0; rd_ack = 1'b0;
    wait_tick();
  endtask

  task automatic pulse_ack;
    rd_ack = 1'b1;
    @(negedge clk);
    rd_ack = 1'b0;
    wait_tick();
  endtask

  task automatic set_cfg(input int nb, input bit pen, input bit podd, input bit two);
    cfg_len = 2'(nb - 5); cfg_par_en = pen; cfg_par_odd = podd; cfg_two_stop = two;
  endtask

  task automatic frame(input logic [7:0] d, input int nb, input bit badpar,
                       input int badstop, input int noisebit);
    logic p;
    p = cfg_par_odd;
    put(1'b0, 16);
    for (int i = 0; i < nb; i++) begin
      p ^= d[i];
      if (i == noisebit) begin
        put(d[i], 8); put(!d[i], 1); put(d[i], 7);
      end else put(d[i], 16);
    end
    if (cfg_par_en) put(p ^ badpar, 16);
    for (int s = 0; s < (cfg_two_stop ? 2 : 1); s++) put(s == badstop ? 1'b0 : 1'b1, 16);
  endtask

  task automatic t_reset;
    chk("R1 valid", rd_valid, 0);
    chk("R1 flags", {err_frame, err_parity, err_noise, err_overrun, brk_det, idle_det}, 0);
  endtask

  task automatic t_basic;
    set_cfg(8, 0, 0, 0); pulse_clear(); put(1'b1, 4);
    frame(8'hA5, 8, 0, -1, -1);
    chk("R3 8N1 valid", rd_valid, 1);
    chk("R3 8N1 data", rd_data, 8'hA5);
    chk("R3 8N1 no errors", {err_frame, err_parity, err_noise, err_overrun}, 0);
    pulse_ack();
    chk("R10 ack clears valid", rd_valid, 0);
  endtask

  task automatic t_parity;
    set_cfg(7, 1, 0, 0); pulse_clear(); put(1'b1, 4);
    frame(8'h35, 7, 0, -1, -1);
    chk("R3 7-bit data", rd_data, 8'h35);
    chk("R4 even parity good", err_parity, 0);
    set_cfg(8, 1, 1, 0); pulse_clear(); put(1'b1, 4);
    frame(8'h3C, 8, 1, -1, -1);
    chk("R4 odd parity bad flagged", err_parity, 1);
    chk("R4 data still delivered", rd_data, 8'h3C);
    pulse_ack();
    chk("R10 ack clears parity flag", err_parity, 0);
    set_cfg(8, 1, 1, 0); put(1'b1, 4);
    frame(8'h3C, 8, 0, -1, -1);
    chk("R4 odd parity good", err_parity, 0);
  endtask

  task automatic t_five;
    set_cfg(5, 0, 0, 0); pulse_clear(); put(1'b1, 4);
    frame(8'hFB, 5, 0, -1, -1);
    chk("R3 5-bit data upper zero", rd_data, 8'h1B);
  endtask

  task automatic t_framing;
    set_cfg(8, 0, 0, 0); pulse_clear(); put(1'b1, 4);
    frame(8'h0F, 8, 0, 0, -1);
    put(1'b1, 20);
    chk("R5 low stop flagged", err_frame, 1);
    set_cfg(8, 0, 0, 1); pulse_clear(); put(1'b1, 4);
    frame(8'hC3, 8, 0, 1, -1);
    put(1'b1, 20);
    chk("R5 second stop low flagged", err_frame, 1);
    chk("R5 8N2 data", rd_data, 8'hC3);
    pulse_clear(); put(1'b1, 4);
    frame(8'h3C, 8, 0, -1, -1);
    chk("R5 good 8N2 no error", err_frame, 0);
  endtask

  task automatic t_glitch;
    set_cfg(8, 0, 0, 0); pulse_clear(); put(1'b1, 4);
    put(1'b0, 4); put(1'b1, 200);
    chk("R2 glitch gives no character", rd_valid, 0);
    frame(8'h66, 8, 0, -1, -1);
    chk("R2 next character after glitch", rd_data, 8'h66);
    chk("R2 next character valid", rd_valid, 1);
  endtask

  task automatic t_noise;
    set_cfg(8, 0, 0, 0); pulse_clear(); put(1'b1, 4);
    frame(8'h5A, 8, 0, -1, 3);
    chk("R6 majority keeps data", rd_data, 8'h5A);
    chk("R6 noise flagged", err_noise, 1);
  endtask

  task automatic t_overrun;
    set_cfg(8, 0, 0, 0); pulse_clear(); put(1'b1, 4);
    frame(8'h11, 8, 0, -1, -1);
    put(1'b1, 4);
    frame(8'h22, 8, 0, -1, -1);
    chk("R7 overrun flagged", err_overrun, 1);
    chk("R7 old data kept", rd_data, 8'h11);
    pulse_ack();
    chk("R7 lost character not queued", rd_valid, 0);
  endtask

  task automatic t_break;
    set_cfg(8, 0, 0, 0); pulse_clear(); put(1'b1, 4);
    put(1'b0, 150);
    chk("R8 no break at 150 low ticks", brk_det, 0);
    put(1'b0, 50);
    chk("R8 break after a frame low", brk_det, 1);
    put(1'b1, 20);
    flag_clear = 1'b1; @(negedge clk); flag_clear = 1'b0; wait_tick();
    chk("R10 flag_clear clears break", brk_det, 0);
  endtask

  task automatic t_idle;
    set_cfg(8, 0, 0, 0); pulse_clear(); put(1'b1, 4);
    frame(8'h77, 8, 0, -1, -1);
    put(1'b1, 100);
    chk("R9 no idle before frame time", idle_det, 0);
    put(1'b1, 100);
    chk("R9 idle after frame time", idle_det, 1);
    flag_clear = 1'b1; @(negedge clk); flag_clear = 1'b0; wait_tick();
    chk("R10 flag_clear clears idle", idle_det, 0);
    chk("R10 flag_clear keeps valid", rd_valid, 1);
    put(1'b1, 200);
    chk("R9 idle fires once per burst", idle_det, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    wait_tick();
    put(1'b1, 4);
    t_basic();
    t_parity();
    t_five();
    t_framing();
    t_glitch();
    t_noise();
    t_overrun();
    t_break();
    t_idle();
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    summary();
    $finish;
  end
endmodule